// File: doc/BRIEF.md
# Two-Channel Timer with Buffered PWM

This block is a free-running up-counter with a programmable wrap limit. The counter feeds two capture/compare channels. Each channel can latch the count when its pin rises, invert its pin when the count reaches a compare value, or produce an edge-aligned PWM waveform. A software-style register port gives access to the limit, the live count, the per-channel settings and values, and the flags. A single interrupt line combines every flag with its own enable bit.

When the link bit of channel 0 is set, the two channels act as one PWM generator on pin 0. Only the compare value of the channel in use sets the pulse width. A new width is written into the other channel's value register, and the generator changes over to it at the next counter wrap, so no period ever mixes two widths. Two settings give exact duty extremes. Clearing toggle-on-wrap holds the output at 0%. Setting both toggle-on-wrap and the full-duty bit holds it at 100%. A `halt` input freezes the counter and suppresses all counter-driven events while every register keeps its value.

Top module: `tmr2_timer`

## Requirements
- R1: After reset the following holds. The count is 0. The limit is all ones. Every flag, enable and setting bit is 0, so both channels are in capture mode (mode code 00). Both pins are undriven, and `irq` is low. The register map is: address 0 status (bit 7 wrap flag, bit 6 wrap interrupt enable), 1 limit, 2 count (read only), 3 channel 0 control, 4 channel 0 value, 5 channel 1 control, 6 channel 1 value.
- R2: While `halt` is low, the count rises by one per clock. In the clock after it equals (or exceeds) the limit, it becomes 0. That wrap sets status bit 7.
- R3: Channel control layout: bit 7 flag, bit 6 interrupt enable, bit 5 link (channel 0 only), bits 3:2 mode (00 capture, 01 toggle, 10 PWM, 11 idle), bit 1 toggle-on-wrap, bit 0 full duty. In capture mode, a rising pin edge latches the count into the value register and sets the flag on the same clock. In toggle and PWM modes, a compare match sets the flag.
- R4: In toggle mode, the pin inverts on the clock after the count equals the channel value.
- R5: In PWM mode with toggle-on-wrap 1 and full duty 0, the pin is high exactly while the count lies between 0 and the compare value inclusive.
- R6: In PWM mode with toggle-on-wrap 0, once the pin is low it stays low (0% duty).
- R7: In PWM mode with toggle-on-wrap 1 and full duty 1, the pin is high from the next clock on (100% duty).
- R8: `irq` is high exactly when some flag and its own enable bit are both set.
- R9: A flag clears only through two steps: the flag is read while set, and then 0 is written to its bit. Writing 1 never sets a flag.
- R10: While `halt` is high, the count holds and no wrap or compare event occurs.
- R11: With link set, pin 0 carries PWM using channel 0's toggle-on-wrap and full-duty bits. The compare value starts as channel 0's value. A write to the value register of the channel not in use moves control to that channel at the next wrap. Pin 1 is then undriven.
- R12: `pin_oe` of a channel is high in toggle and PWM modes and low in capture and idle modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Freezes the counter and its events |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (arms flag clearing) |
| addr | input | AW | Register address |
| wdata | input | CW | Write data |
| rdata | output | CW | Read data for `addr`, combinational |
| pin_in | input | 2 | Channel pin inputs for capture |
| pin_out | output | 2 | Channel pin output levels |
| pin_oe | output | 2 | Channel pin drive enables |
| irq | output | 1 | Combined interrupt request |

## Verification
Read data is combinational, so the scoreboard compares each queued expectation in the same cycle as its read strobe. The comparison happens three quarters into the cycle. Writes, wrap flags and capture flags take effect on the edge that ends the cycle in which the cause was present. Pin levels follow one edge after the count value that caused them. The pin checks therefore pair each sampled pin with the count sampled in the same cycle, and they detect a wrap from the previous cycle's sample. Stimuli that could collide with a wrap edge are applied while `halt` is high, so the cycle in which each result is due stays unambiguous.

// File: rtl/tmr2_pkg.sv
`timescale 1ns/1ps
package tmr2_pkg;
   typedef enum logic [1:0] {
      CH_CAPTURE = 2'b00,
      CH_TOGGLE  = 2'b01,
      CH_PWM     = 2'b10,
      CH_IDLE    = 2'b11
   } ch_mode_e;

   localparam int unsigned REG_STAT  = 0;
   localparam int unsigned REG_MOD   = 1;
   localparam int unsigned REG_CNT   = 2;
   localparam int unsigned REG_C0CTL = 3;
   localparam int unsigned REG_C0VAL = 4;
   localparam int unsigned REG_C1CTL = 5;
   localparam int unsigned REG_C1VAL = 6;

   localparam int unsigned B_FLAG    = 7;
   localparam int unsigned B_IE      = 6;
   localparam int unsigned B_LINK    = 5;
   localparam int unsigned B_MODE_LO = 2;
   localparam int unsigned B_TOV     = 1;
   localparam int unsigned B_MAX     = 0;

   typedef struct packed {
      logic     ie;
      logic     link;
      ch_mode_e mode;
      logic     tov;
      logic     maxd;
   } ch_cfg_t;
endpackage

// File: rtl/tmr2_counter.sv
`timescale 1ns/1ps
module tmr2_counter #(
   parameter int unsigned CW = 16
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          halt,
   input  logic [CW-1:0] limit,
   output logic [CW-1:0] count,
   output logic          wrap
);
   if (CW < 2) begin : g_bad_cw
      $error("tmr2_counter: CW must be at least 2");
   end

   assign wrap = !halt && (count >= limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count <= '0;
      else if (!halt)
         count <= wrap ? '0 : count + 1'b1;
   end

   // R2: wrap returns to zero, otherwise single steps
   a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == '0));
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!halt && count < limit) |=> (count == CW'($past(count) + 1'b1)));
   // R10: halted counter holds
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> $stable(count));
endmodule

// File: rtl/tmr2_channel.sv
`timescale 1ns/1ps
module tmr2_channel import tmr2_pkg::*; #(
   parameter int unsigned CW        = 16,
   parameter bit          CAPT_SYNC = 1'b0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          wrap,
   input  logic [CW-1:0] count,
   input  logic [CW-1:0] cmp,
   input  ch_mode_e      mode,
   input  logic          tov,
   input  logic          maxd,
   input  logic          pin_in,
   output logic          pin_out,
   output logic          event_hit
);
   logic pin_s, pin_q, rise, match;

   if (CAPT_SYNC) begin : g_sync
      logic [1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= {sr[0], pin_in};
      end
      assign pin_s = sr[1];
   end else begin : g_direct
      assign pin_s = pin_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_q <= 1'b0;
      else        pin_q <= pin_s;
   end

   assign rise  = pin_s & ~pin_q;
   assign match = run && (count == cmp);

   always_comb begin
      case (mode)
         CH_CAPTURE:      event_hit = rise;
         CH_TOGGLE,
         CH_PWM:          event_hit = match;
         default:         event_hit = 1'b0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pin_out <= 1'b0;
      end else if (mode == CH_TOGGLE) begin
         if (match) pin_out <= ~pin_out;
      end else if (mode == CH_PWM) begin
         if (tov && (maxd || wrap)) pin_out <= 1'b1;
         else if (match)            pin_out <= 1'b0;
      end
   end

   // R7: full duty holds the pin high
   a_r7_full_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CH_PWM && tov && maxd) |=> pin_out);
   // R6: without toggle-on-wrap a low pin stays low
   a_r6_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CH_PWM && !tov && !pin_out) |=> !pin_out);
   // R4: toggle on compare
   a_r4_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CH_TOGGLE && run && count == cmp) |=> (pin_out != $past(pin_out)));
endmodule

// File: rtl/tmr2_timer.sv
`timescale 1ns/1ps
module tmr2_timer import tmr2_pkg::*; #(
   parameter int unsigned CW        = 16,
   parameter int unsigned AW        = 3,
   parameter bit          CAPT_SYNC = 1'b0
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          halt,
   input  logic          wr_en,
   input  logic          rd_en,
   input  logic [AW-1:0] addr,
   input  logic [CW-1:0] wdata,
   output logic [CW-1:0] rdata,
   input  logic [1:0]    pin_in,
   output logic [1:0]    pin_out,
   output logic [1:0]    pin_oe,
   output logic          irq
);
   localparam int unsigned NCH = 2;
   localparam logic [AW-1:0] A_STAT  = AW'(REG_STAT);
   localparam logic [AW-1:0] A_MOD   = AW'(REG_MOD);
   localparam logic [AW-1:0] A_CNT   = AW'(REG_CNT);
   localparam logic [AW-1:0] A_C0CTL = AW'(REG_C0CTL);
   localparam logic [AW-1:0] A_C0VAL = AW'(REG_C0VAL);
   localparam logic [AW-1:0] A_C1CTL = AW'(REG_C1CTL);
   localparam logic [AW-1:0] A_C1VAL = AW'(REG_C1VAL);

   if (CW < 8 || CW > 32) begin : g_bad_cw
      $error("tmr2_timer: CW must lie in 8..32");
   end
   if (AW < 3) begin : g_bad_aw
      $error("tmr2_timer: AW must be at least 3");
   end

   function automatic logic [CW-1:0] ctl_word(input ch_cfg_t c, input logic f);
      logic [CW-1:0] w;
      w              = '0;
      w[B_FLAG]      = f;
      w[B_IE]        = c.ie;
      w[B_LINK]      = c.link;
      w[B_MODE_LO+:2] = c.mode;
      w[B_TOV]       = c.tov;
      w[B_MAX]       = c.maxd;
      return w;
   endfunction

   logic [CW-1:0]  limit, count;
   logic           wrap;
   logic           ovf_flag, ovf_ie, ovf_arm;
   logic           sel, pend, link, wr_spare;
   ch_cfg_t        cfg_w [NCH];
   logic [CW-1:0]  val_w [NCH];
   logic [NCH-1:0] chf, cie;

   tmr2_counter #(.CW(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .halt(halt),
      .limit(limit), .count(count), .wrap(wrap)
   );

   assign link = cfg_w[0].link;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         limit    <= '1;
         ovf_ie   <= 1'b0;
         ovf_flag <= 1'b0;
         ovf_arm  <= 1'b0;
      end else begin
         if (wr_en && addr == A_MOD)  limit  <= wdata;
         if (wr_en && addr == A_STAT) ovf_ie <= wdata[B_IE];
         if (wrap)
            ovf_flag <= 1'b1;
         else if (wr_en && addr == A_STAT && !wdata[B_FLAG] && ovf_arm)
            ovf_flag <= 1'b0;
         if (wr_en && addr == A_STAT)                   ovf_arm <= 1'b0;
         else if (rd_en && addr == A_STAT && ovf_flag)  ovf_arm <= 1'b1;
      end
   end

   // buffered PWM: which channel's value is in use, and a pending changeover
   assign wr_spare = wr_en && (addr == (sel ? A_C0VAL : A_C1VAL));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel  <= 1'b0;
         pend <= 1'b0;
      end else if (!link) begin
         sel  <= 1'b0;
         pend <= 1'b0;
      end else begin
         if (wrap && pend) sel <= ~sel;
         if (wr_spare)     pend <= 1'b1;
         else if (wrap)    pend <= 1'b0;
      end
   end

   for (genvar gi = 0; gi < NCH; gi++) begin : g_ch
      localparam logic [AW-1:0] A_CTL = AW'(REG_C0CTL + 2*gi);
      localparam logic [AW-1:0] A_VAL = AW'(REG_C0VAL + 2*gi);
      ch_cfg_t       cfg_q;
      logic [CW-1:0] val_q, cmp;
      logic          flag_q, arm_q, hit;
      ch_mode_e      mode_eff;

      if (gi == 0) begin : g_lead
         assign mode_eff = link ? CH_PWM : cfg_q.mode;
         assign cmp      = (link && sel) ? val_w[1] : val_q;
      end else begin : g_follow
         assign mode_eff = link ? CH_IDLE : cfg_q.mode;
         assign cmp      = val_q;
      end

      tmr2_channel #(.CW(CW), .CAPT_SYNC(CAPT_SYNC)) u_ch (
         .clk(clk), .rst_n(rst_n), .run(!halt), .wrap(wrap),
         .count(count), .cmp(cmp), .mode(mode_eff),
         .tov(cfg_q.tov), .maxd(cfg_q.maxd),
         .pin_in(pin_in[gi]), .pin_out(pin_out[gi]), .event_hit(hit)
      );

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cfg_q  <= '0;
            val_q  <= '0;
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
         end else begin
            if (wr_en && addr == A_CTL) begin
               cfg_q.ie   <= wdata[B_IE];
               cfg_q.link <= (gi == 0) ? wdata[B_LINK] : 1'b0;
               cfg_q.mode <= ch_mode_e'(wdata[B_MODE_LO+:2]);
               cfg_q.tov  <= wdata[B_TOV];
               cfg_q.maxd <= wdata[B_MAX];
            end
            if (hit && mode_eff == CH_CAPTURE)  val_q <= count;
            else if (wr_en && addr == A_VAL)    val_q <= wdata;
            if (hit)
               flag_q <= 1'b1;
            else if (wr_en && addr == A_CTL && !wdata[B_FLAG] && arm_q)
               flag_q <= 1'b0;
            if (wr_en && addr == A_CTL)                  arm_q <= 1'b0;
            else if (rd_en && addr == A_CTL && flag_q)   arm_q <= 1'b1;
         end
      end

      assign cfg_w[gi]  = cfg_q;
      assign val_w[gi]  = val_q;
      assign chf[gi]    = flag_q;
      assign cie[gi]    = cfg_q.ie;
      assign pin_oe[gi] = (mode_eff == CH_TOGGLE) || (mode_eff == CH_PWM);

      // R3: every channel event leaves the flag set
      a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
         hit |=> flag_q);
   end

   always_comb begin
      rdata = '0;
      case (addr)
         A_STAT: begin
            rdata[B_FLAG] = ovf_flag;
            rdata[B_IE]   = ovf_ie;
         end
         A_MOD:   rdata = limit;
         A_CNT:   rdata = count;
         A_C0CTL: rdata = ctl_word(cfg_w[0], chf[0]);
         A_C0VAL: rdata = val_w[0];
         A_C1CTL: rdata = ctl_word(cfg_w[1], chf[1]);
         A_C1VAL: rdata = val_w[1];
         default: rdata = '0;
      endcase
   end

   assign irq = (ovf_flag & ovf_ie) | (|(chf & cie));

   // R9: software cannot raise the wrap flag
   a_r9_no_sw_set: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_flag && !wrap) |=> !ovf_flag);
   // R10: no wrap flag while halted
   a_r10_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (halt && !ovf_flag && !(wr_en && addr == A_STAT)) |=> !ovf_flag);
   // R11: the active buffer only changes at a wrap
   a_r11_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (link && !wrap && !(wr_en && addr == A_C0CTL)) |=> $stable(sel));
   // R8: no flag, no request
   a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!ovf_flag && chf == '0) |-> !irq);
endmodule

// File: tb/tmr2_timer_test.sv
`timescale 1ns/1ps
module tmr2_timer_test;
   import tmr2_pkg::*;
   localparam int CLK_P = 10;
   localparam int Q     = CLK_P / 4;

   logic        clk = 1'b0;
   logic        rst_n, halt, wr_en, rd_en, irq;
   logic [2:0]  addr;
   logic [15:0] wdata, rdata;
   logic [1:0]  pin_in, pin_out, pin_oe;

   int n_run = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [15:0] q_exp[$];
   string       q_req[$];

   always #(CLK_P/2) clk = ~clk;

   tmr2_timer uut (
      .clk(clk), .rst_n(rst_n), .halt(halt), .wr_en(wr_en), .rd_en(rd_en),
      .addr(addr), .wdata(wdata), .rdata(rdata),
      .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_run++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic report();
      $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
   endtask

   // scoreboard monitor: compares every read strobe against the queue
   initial begin
      forever begin
         @(negedge clk);
         #(Q);
         if (rd_en) begin
            if (q_exp.size() == 0) check("scoreboard", 1, 0);
            else check(q_req.pop_front(), rdata, q_exp.pop_front());
         end
      end
   end

   task automatic tick();
      @(negedge clk);
      wr_en = 1'b0;
      rd_en = 1'b0;
   endtask

   task automatic wr(input int a, input logic [15:0] d);
      @(negedge clk);
      addr  = 3'(a);
      wdata = d;
      wr_en = 1'b1;
      rd_en = 1'b0;
   endtask

   task automatic rd_exp(input int a, input logic [15:0] e, input string req);
      @(negedge clk);
      addr  = 3'(a);
      wr_en = 1'b0;
      rd_en = 1'b1;
      q_exp.push_back(e);
      q_req.push_back(req);
   endtask

   task automatic settle();
      @(negedge clk);
      wr_en = 1'b0;
      rd_en = 1'b0;
      addr  = 3'(REG_CNT);
      #(Q);
   endtask

   task automatic peek(input int a, output logic [15:0] v);
      @(negedge clk);
      wr_en = 1'b0;
      rd_en = 1'b0;
      addr  = 3'(a);
      #(Q);
      v = rdata;
   endtask

   // pin 0 must be high exactly while count <= active compare
   task automatic watch_pwm(input int cycles, input int lim, input int cmp_a,
                            input int cmp_b, input logic [15:0] prev0,
                            input string req, output bit swapped);
      logic [15:0] prev, c;
      int cur;
      cur = cmp_a;
      prev = prev0;
      swapped = 1'b0;
      for (int k = 0; k < cycles; k++) begin
         settle();
         c = rdata;
         if (!swapped && cmp_a != cmp_b && prev == 16'(lim) && c == 16'd0) begin
            cur = cmp_b;
            swapped = 1'b1;
         end
         check(req, {31'd0, pin_out[0]}, {31'd0, (int'(c) <= cur)});
         prev = c;
      end
   endtask

   task automatic watch_toggle(input int cycles, input int cmp);
      logic [15:0] prev, c;
      logic expv;
      settle();
      prev = rdata;
      expv = pin_out[1];
      for (int k = 0; k < cycles; k++) begin
         settle();
         c = rdata;
         if (prev == 16'(cmp)) expv = ~expv;
         check("R4 toggle", {31'd0, pin_out[1]}, {31'd0, expv});
         prev = c;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         check("watchdog", 1, 0);
         report();
         $finish;
      end
   end

   initial begin
      logic [15:0] c0;
      bit sw;
      rst_n = 1'b0; halt = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
      addr = '0; wdata = '0; pin_in = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd_exp(REG_STAT, 16'h0000, "R1 status");
      rd_exp(REG_MOD, 16'hFFFF, "R1 limit");
      rd_exp(REG_CNT, 16'h0000, "R1 count");
      rd_exp(REG_C0CTL, 16'h0000, "R1 ch0 ctl");
      rd_exp(REG_C1CTL, 16'h0000, "R1 ch1 ctl");
      settle();
      check("R1 pins", {30'd0, pin_out}, 0);
      check("R1 R12 oe", {30'd0, pin_oe}, 0);
      check("R1 irq", {31'd0, irq}, 0);

      // R2 counting and wrap
      wr(REG_MOD, 16'd4);
      rd_exp(REG_CNT, 16'd0, "R2 count");
      halt = 1'b0;
      for (int k = 1; k <= 4; k++) rd_exp(REG_CNT, 16'(k), "R2 count");
      rd_exp(REG_CNT, 16'd0, "R2 wrap");
      halt = 1'b1;
      // R10 frozen
      rd_exp(REG_CNT, 16'd0, "R10 hold");
      rd_exp(REG_CNT, 16'd0, "R10 hold");

      // R9 flag clearing protocol
      wr(REG_STAT, 16'h0000);
      rd_exp(REG_STAT, 16'h0080, "R9 R2 flag kept without read");
      wr(REG_STAT, 16'h0000);
      rd_exp(REG_STAT, 16'h0000, "R9 flag cleared");
      wr(REG_STAT, 16'h0080);
      rd_exp(REG_STAT, 16'h0000, "R9 no sw set");

      // R8 interrupt from wrap
      wr(REG_STAT, 16'h0040);
      settle();
      check("R8 no flag", {31'd0, irq}, 0);
      halt = 1'b0;
      repeat (6) tick();
      halt = 1'b1;
      settle();
      check("R8 wrap irq", {31'd0, irq}, 1);
      wr(REG_STAT, 16'h0000);
      settle();
      check("R8 enable off", {31'd0, irq}, 0);
      rd_exp(REG_STAT, 16'h0080, "R9 flag kept");
      wr(REG_STAT, 16'h0000);
      rd_exp(REG_STAT, 16'h0000, "R9 cleared");

      // R3 capture on channel 1 while halted
      peek(REG_CNT, c0);
      wr(REG_C1CTL, 16'h0040);
      @(negedge clk); wr_en = 1'b0; pin_in[1] = 1'b1;
      @(negedge clk); pin_in[1] = 1'b0;
      rd_exp(REG_C1VAL, c0, "R3 captured value");
      rd_exp(REG_C1CTL, 16'h00C0, "R3 capture flag");
      settle();
      check("R8 channel irq", {31'd0, irq}, 1);
      check("R12 capture oe", {31'd0, pin_oe[1]}, 0);
      wr(REG_C1CTL, 16'h0040);
      rd_exp(REG_C1CTL, 16'h0040, "R9 channel flag cleared");

      // R4 toggle mode on channel 1
      wr(REG_MOD, 16'd9);
      wr(REG_C1VAL, 16'd5);
      wr(REG_C1CTL, 16'h0004);
      tick();
      halt = 1'b0;
      watch_toggle(35, 5);
      halt = 1'b1;
      settle();
      check("R12 toggle oe", {31'd0, pin_oe[1]}, 1);
      rd_exp(REG_C1CTL, 16'h0084, "R3 compare flag");

      // R5 PWM on channel 0
      wr(REG_C0VAL, 16'd3);
      wr(REG_C0CTL, 16'h000A);
      tick();
      halt = 1'b0;
      repeat (12) tick();
      watch_pwm(25, 9, 3, 3, 16'hFFFF, "R5 duty", sw);

      // R6 zero duty
      wr(REG_C0CTL, 16'h0008);
      repeat (12) tick();
      for (int k = 0; k < 20; k++) begin
         settle();
         check("R6 zero duty", {31'd0, pin_out[0]}, 0);
      end

      // R7 full duty
      wr(REG_C0CTL, 16'h000B);
      tick();
      for (int k = 0; k < 20; k++) begin
         settle();
         check("R7 full duty", {31'd0, pin_out[0]}, 1);
      end

      // R11 linked buffered PWM
      wr(REG_C0CTL, 16'h0022);
      repeat (12) tick();
      halt = 1'b1;
      wr(REG_C1VAL, 16'd7);
      tick();
      peek(REG_CNT, c0);
      halt = 1'b0;
      watch_pwm(30, 9, 3, 7, c0, "R11 buffered duty", sw);
      check("R11 changeover seen", {31'd0, sw}, 1);
      settle();
      check("R11 R12 linked oe", {30'd0, pin_oe}, 32'd1);

      halt = 1'b1;
      repeat (3) tick();
      check("scoreboard drained", q_exp.size(), 0);
      done = 1'b1;
      report();
      $finish;
   end
endmodule